// File: doc/BRIEF.md
# Three-State Power Mode Controller

This block holds the chip's power mode and moves it among three levels: awake (nominal power), light sleep (intermediate power) and deep sleep (lowest power). It watches a host idle request, a host wake-up request, a serial-port request for the system clock, a bus of external clock requests, and a software bit that permits the deepest mode. It also watches a bus of force sources: hardware reset, software reset, watchdog time-out and a software clock request. Any one of these returns the chip to awake.

From its registered mode the block drives registered enables for three clock domains: the 32 kHz low-frequency clock, the system clock, and the 48 MHz high-frequency clock. It also drives a per-peripheral enable for the output clocks. Deep sleep keeps only the low-frequency clock running, for wake-up detection and for the serial-port functional clock. Light sleep keeps the system clock and the low-frequency clock, and passes each peripheral clock only while that peripheral requests it. Awake turns everything on. An external clock request pulls deep sleep up only as far as light sleep. All inputs are sampled as levels on the clock edge.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the mode becomes awake (code 00), `en_lf`, `en_sys` and `en_hf` become 1, and `periph_en` becomes all ones.
- R2: If any bit of `force_awake` is 1 at an edge, the next mode is awake, whatever the other inputs are.
- R3: In awake, with `idle_req` high and no wake source, the next mode is deep sleep if `deep_en` is 1 and no `ext_clk_req` bit is set. Otherwise the next mode is light sleep.
- R4: In light sleep with no wake source, the next mode is deep sleep when `deep_en` is 1 and no `ext_clk_req` bit is set. Otherwise it stays light sleep.
- R5: In deep sleep with no wake source, any `ext_clk_req` bit moves the mode to light sleep. Otherwise it stays deep sleep.
- R6: The wake sources are `wake_req` and `uart_clk_req`. Either one at an edge makes the next mode awake from either sleep mode. In awake, either one keeps the mode awake even when `idle_req` is high.
- R7: The enables are registered and follow the new mode in the same cycle. In awake, `en_lf`, `en_sys` and `en_hf` are all 1 and `periph_en` is all ones. In light sleep, `en_lf` and `en_sys` are 1, `en_hf` is 0, and `periph_en` equals `periph_req` as sampled at the same edge. In deep sleep, only `en_lf` is 1 and `periph_en` is zero.
- R8: `mode` is encoded as 00 = awake, 01 = light sleep, 10 = deep sleep, and never shows 11.
- R9: In awake, with no idle request and no force source, the mode stays awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Host idle request |
| wake_req | input | 1 | Host wake-up request |
| uart_clk_req | input | 1 | Serial-port request for the system clock |
| ext_clk_req | input | N_EXT | External clock requests |
| deep_en | input | 1 | Software permission for deep sleep |
| force_awake | input | N_FORCE | Reset, watchdog and software clock request sources |
| periph_req | input | N_PERIPH | Per-peripheral output clock requests |
| mode | output | 2 | Current mode code |
| en_lf | output | 1 | Low-frequency clock enable |
| en_sys | output | 1 | System clock enable |
| en_hf | output | 1 | High-frequency clock enable |
| periph_en | output | N_PERIPH | Per-peripheral output clock enables |

## Verification
The bench puts the block in each of the three modes in turn. From each one it applies all 64 combinations of force, wake-up, serial-port request, idle, external request and deep-enable. This separates the priority of force over wake, and of wake over idle. It also separates the two sleep targets reached from awake, and the deep-sleep exit that stops at light sleep. The force and external request buses rotate which bit is set, so each bit is shown to count. The peripheral request pattern changes with every combination, which shows that peripheral gating follows the requests only in light sleep. A reference model in the bench computes the expected mode and every enable.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    M_AWAKE = 2'b00,
    M_LIGHT = 2'b01,
    M_DEEP  = 2'b10
  } pmode_t;

  typedef struct packed {
    logic lf;
    logic sys;
    logic hf;
  } clk_en_t;
endpackage

// File: rtl/pwr_req_merge.sv
module pwr_req_merge #(
  parameter int N_EXT   = 2,
  parameter int N_FORCE = 3
) (
  input  logic               wake_req,
  input  logic               uart_clk_req,
  input  logic [N_EXT-1:0]   ext_clk_req,
  input  logic [N_FORCE-1:0] force_awake,
  output logic               wake_any,
  output logic               ext_any,
  output logic               force_any
);
  assign wake_any  = wake_req | uart_clk_req;
  assign ext_any   = |ext_clk_req;
  assign force_any = |force_awake;
endmodule

// File: rtl/pwr_mode_next.sv
module pwr_mode_next
  import pwr_mode_pkg::*;
(
  input  pmode_t cur,
  input  logic   force_any,
  input  logic   wake_any,
  input  logic   idle_req,
  input  logic   ext_any,
  input  logic   deep_en,
  output pmode_t nxt
);
  logic deep_ok;
  assign deep_ok = deep_en & ~ext_any;

  always_comb begin
    nxt = cur;
    if (force_any) begin
      nxt = M_AWAKE;
    end else begin
      case (cur)
        M_AWAKE: begin
          if (!wake_any && idle_req) nxt = deep_ok ? M_DEEP : M_LIGHT;
        end
        M_LIGHT: begin
          if (wake_any)     nxt = M_AWAKE;
          else if (deep_ok) nxt = M_DEEP;
        end
        M_DEEP: begin
          if (wake_any)     nxt = M_AWAKE;
          else if (ext_any) nxt = M_LIGHT;
        end
        default: nxt = M_AWAKE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_clk_decode.sv
module pwr_clk_decode
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input  pmode_t              m,
  input  logic [N_PERIPH-1:0] periph_req,
  output clk_en_t             en,
  output logic [N_PERIPH-1:0] periph_en
);
  always_comb begin
    en.lf  = 1'b1;
    en.sys = (m != M_DEEP);
    en.hf  = (m == M_AWAKE);
  end

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
    always_comb begin
      case (m)
        M_AWAKE: periph_en[g] = 1'b1;
        M_LIGHT: periph_en[g] = periph_req[g];
        default: periph_en[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_EXT    = 2,
  parameter int N_FORCE  = 3,
  parameter int N_PERIPH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idle_req,
  input  logic                wake_req,
  input  logic                uart_clk_req,
  input  logic [N_EXT-1:0]    ext_clk_req,
  input  logic                deep_en,
  input  logic [N_FORCE-1:0]  force_awake,
  input  logic [N_PERIPH-1:0] periph_req,
  output logic [1:0]          mode,
  output logic                en_lf,
  output logic                en_sys,
  output logic                en_hf,
  output logic [N_PERIPH-1:0] periph_en
);
  localparam logic [N_PERIPH-1:0] PERIPH_ALL = '1;

  logic wake_any, ext_any, force_any;
  pmode_t mode_q, mode_d;
  clk_en_t en_d, en_q;
  logic [N_PERIPH-1:0] periph_d, periph_q;

  pwr_req_merge #(.N_EXT(N_EXT), .N_FORCE(N_FORCE)) u_merge (
    .wake_req(wake_req), .uart_clk_req(uart_clk_req),
    .ext_clk_req(ext_clk_req), .force_awake(force_awake),
    .wake_any(wake_any), .ext_any(ext_any), .force_any(force_any)
  );

  pwr_mode_next u_next (
    .cur(mode_q), .force_any(force_any), .wake_any(wake_any),
    .idle_req(idle_req), .ext_any(ext_any), .deep_en(deep_en),
    .nxt(mode_d)
  );

  pwr_clk_decode #(.N_PERIPH(N_PERIPH)) u_dec (
    .m(mode_d), .periph_req(periph_req), .en(en_d), .periph_en(periph_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_AWAKE;
      en_q     <= '{lf: 1'b1, sys: 1'b1, hf: 1'b1};
      periph_q <= PERIPH_ALL;
    end else begin
      mode_q   <= mode_d;
      en_q     <= en_d;
      periph_q <= periph_d;
    end
  end

  assign mode      = mode_q;
  assign en_lf     = en_q.lf;
  assign en_sys    = en_q.sys;
  assign en_hf     = en_q.hf;
  assign periph_en = periph_q;

  p_force_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (|force_awake) |=> (mode == 2'b00));

  p_deep_guard_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode != 2'b10) && !force_any && (mode_d == M_DEEP)) |-> (deep_en && !(|ext_clk_req)));

  p_deep_exit_light_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b10) && (|ext_clk_req) && !wake_req && !uart_clk_req && !(|force_awake))
    |=> (mode == 2'b01));

  p_wake_return_r6: assert property (@(posedge clk) disable iff (rst)
    ((wake_req || uart_clk_req) && (mode != 2'b00)) |=> (mode == 2'b00));

  p_deep_clocks_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (en_lf && !en_sys && !en_hf && (periph_en == '0)));

  p_awake_clocks_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> (en_lf && en_sys && en_hf && (periph_en == PERIPH_ALL)));

  p_legal_code_r8: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b11);

  p_awake_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b00) && !idle_req && !(|force_awake)) |=> (mode == 2'b00));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int NE = 2, NF = 3, NP = 4;

  logic clk = 1'b0;
  logic rst, idle_req, wake_req, uart_clk_req, deep_en;
  logic [NE-1:0] ext_clk_req;
  logic [NF-1:0] force_awake;
  logic [NP-1:0] periph_req;
  logic [1:0] mode;
  logic en_lf, en_sys, en_hf;
  logic [NP-1:0] periph_en;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.N_EXT(NE), .N_FORCE(NF), .N_PERIPH(NP)) i_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .idle_req(idle_req), .wake_req(wake_req),
    .uart_clk_req(uart_clk_req), .ext_clk_req(ext_clk_req), .deep_en(deep_en),
    .force_awake(force_awake), .periph_req(periph_req), .mode(mode),
    .en_lf(en_lf), .en_sys(en_sys), .en_hf(en_hf), .periph_en(periph_en)
  );

  function automatic int model(int m, bit f, bit w, bit i, bit e, bit d);
    if (f) return 0;
    if (m == 0) return (!w && i) ? ((d && !e) ? 2 : 1) : 0;
    if (w) return 0;
    if (m == 1) return (d && !e) ? 2 : 1;
    return e ? 1 : 2;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(string tag, int m, logic [NP-1:0] req);
    logic [NP-1:0] pexp;
    pexp = (m == 0) ? '1 : (m == 1) ? req : '0;
    check(tag, int'(mode), m);
    check("R8 code", int'(mode != 2'b11), 1);
    check("R7 lf/sys/hf", int'({en_lf, en_sys, en_hf}),
          int'({1'b1, m != 2, m == 0}));
    check("R7 periph", int'(periph_en), int'(pexp));
  endtask

  task automatic idle_all();
    idle_req = 0; wake_req = 0; uart_clk_req = 0; deep_en = 0;
    ext_clk_req = '0; force_awake = '0; periph_req = '0;
  endtask

  task automatic goto_mode(int s);
    @(negedge clk); idle_all(); rst = 1;
    @(negedge clk); rst = 0;
    if (s != 0) begin
      idle_req = 1; deep_en = (s == 2);
      @(negedge clk); idle_all();
    end
    check_outputs(s == 0 ? "R1 reset" : "R3 entry", s, '0);
  endtask

  initial begin
    rst = 1; idle_all();
    @(negedge clk); @(negedge clk);
    check_outputs("R1 reset", 0, '0);
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 64; c++) begin
        bit f, w, u, i, e, d;
        int exp;
        string tag;
        goto_mode(s);
        f = c[0]; w = c[1]; u = c[2]; i = c[3]; e = c[4]; d = c[5];
        force_awake  = f ? NF'(1 << (c % NF)) : '0;
        wake_req     = w;
        uart_clk_req = u;
        idle_req     = i;
        ext_clk_req  = e ? ((c >> 1) % 2 == 1 ? NE'(2) : NE'(1)) : '0;
        deep_en      = d;
        periph_req   = NP'(c + s);
        exp = model(s, f, w | u, i, e, d);
        if (f) tag = "R2 force";
        else if ((w | u) && (s != 0 || i)) tag = "R6 wake";
        else if (s == 0) tag = i ? "R3 idle" : "R9 hold";
        else if (s == 1) tag = "R4 light";
        else tag = "R5 deep";
        @(negedge clk);
        check_outputs(tag, exp, NP'(c + s));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule